// File: doc/BRIEF.md
# Transition-Filtered Status Register Group

This block collects abnormal-condition flags for an instrument controller and turns them into one summary bit. A vector of live condition inputs is compared every clock with its value from the previous clock. Two per-bit masks pick which edges count. The rising mask passes 0-to-1 changes and the falling mask passes 1-to-0 changes. A passed edge sets the matching bit of a sticky event register. Reading that register returns its value and clears it.

An enable mask selects which event bits feed an OR. The result is exported as a summary bit. It also appears at a fixed position of an 8-bit status-byte fragment. Every other bit of that fragment is zero.

The host reaches the registers through a small port: a 3-bit address, read and write strobes, 16-bit write data, and registered read data. The read data is valid on the cycle after the read strobe. The condition inputs are assumed to be synchronous to `clk` already.

Top module: `status_group`

## Requirements
- R1: After reset the rising mask is 16'hFFFF, the falling mask is 16'h0000, the enable mask is 16'h0000 and the event register is 16'h0000. Both the summary bit and the status fragment read zero.
- R2: Address 0 returns the condition inputs as sampled at the read-strobe edge. Writes to address 0 have no effect.
- R3: Where the rising mask (address 1, read/write) has a 1, a 0-to-1 change of that condition bit sets the matching event bit on the clock edge where the change is first seen.
- R4: Where the falling mask (address 2, read/write) has a 1, a 1-to-0 change sets the matching event bit. Where the relevant mask bit is 0, the edge sets nothing.
- R5: An event bit stays set after its condition returns to its earlier level, until the event register is read.
- R6: A read of address 3 returns the event register as it was before the strobe edge and clears it at that edge. Read data is valid one cycle after the strobe.
- R7: If a filtered edge and an event read fall on the same edge, the read returns the old value and the newly set bit remains set afterwards.
- R8: Writes to address 3 leave the event register unchanged.
- R9: The enable mask sits at address 4 and is read/write. The summary bit is the OR of (event AND enable). It follows either register in the same cycle that register changes.
- R10: The status fragment carries the summary at bit 3, and all its other bits are 0.
- R11: Reads of addresses 5 to 7 return zero, and writes to them change no register.
- R12: Condition levels that are present while reset is asserted do not produce events when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_i | input | 16 | Live condition flags, synchronous to clk |
| host_addr | input | 3 | Register select: 0 cond, 1 rise mask, 2 fall mask, 3 event, 4 enable |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid the cycle after host_rd |
| sum_o | output | 1 | OR of enabled event bits |
| status_bits_o | output | 8 | Status fragment with the summary at bit 3 |

## Verification
The hardest case to reach from the ports is a condition edge that lands on the same clock edge as an event read. In that case the clear and the set compete. The bench first loads one event bit. It then raises the read strobe and changes a condition bit at the same falling clock edge, so both take effect on the next rising edge. A second read then shows that only the new bit survived. The reset case is also set up on purpose: the conditions are held high during reset, which shows that no edge is inferred when reset is released.

// File: rtl/stat_pkg.sv
// Package: shared register map for the status register group.
// Assumes a 3-bit host address; codes 5..7 are unused.
package stat_pkg;
    typedef enum logic [2:0] {
        SA_COND = 3'd0,
        SA_RISE = 3'd1,
        SA_FALL = 3'd2,
        SA_EVT  = 3'd3,
        SA_MASK = 3'd4
    } stat_addr_e;
    localparam int unsigned STAT_AW = 3;
endpackage

// File: rtl/stat_edge.sv
// stat_edge: remembers the previous condition vector and flags the
// edges passed by the rising and falling masks.
// Assumes cond_i is synchronous; during reset the history register
// loads the live value so no edge appears at reset release.
module stat_edge #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_i,
    input  logic [W-1:0] rise_m,
    input  logic [W-1:0] fall_m,
    output logic [W-1:0] cond_q,
    output logic [W-1:0] hit
);
    logic [W-1:0] up_e;
    logic [W-1:0] dn_e;

    // history register: previous cycle's condition vector
    always_ff @(posedge clk) begin
        cond_q <= cond_i;
    end

    // edge masks: a bit fires on a filtered change this cycle
    always_comb begin
        up_e = cond_i & ~cond_q;
        dn_e = ~cond_i & cond_q;
        hit  = rst_n ? ((up_e & rise_m) | (dn_e & fall_m)) : '0;
    end
endmodule

// File: rtl/stat_evt.sv
// stat_evt: sticky event register, cleared by a read strobe.
// A bit set by hit on the clearing edge survives the clear.
module stat_evt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic         clr,
    output logic [W-1:0] evt_q
);
    // latch filtered edges; a read clears, new hits win
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= '0;
        else if (clr)
            evt_q <= hit;
        else
            evt_q <= evt_q | hit;
    end
endmodule

// File: rtl/stat_regs.sv
// stat_regs: host-writable masks and the registered read mux.
// Assumes the map in stat_pkg; condition and event are read-only here.
module stat_regs
    import stat_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STAT_AW-1:0] addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [W-1:0]       wdata,
    input  logic [W-1:0]       cond_i,
    input  logic [W-1:0]       evt_q,
    output logic [W-1:0]       rise_m,
    output logic [W-1:0]       fall_m,
    output logic [W-1:0]       ena_m,
    output logic [W-1:0]       rdata
);
    logic [W-1:0] rd_mux;

    // mask writes; other addresses are ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_m <= '1;
            fall_m <= '0;
            ena_m  <= '0;
        end else if (wr) begin
            case (addr)
                SA_RISE: rise_m <= wdata;
                SA_FALL: fall_m <= wdata;
                SA_MASK: ena_m  <= wdata;
                default: ;
            endcase
        end
    end

    // select the register named by the address
    always_comb begin
        case (addr)
            SA_COND: rd_mux = cond_i;
            SA_RISE: rd_mux = rise_m;
            SA_FALL: rd_mux = fall_m;
            SA_EVT:  rd_mux = evt_q;
            SA_MASK: rd_mux = ena_m;
            default: rd_mux = '0;
        endcase
    end

    // read data register, loaded on the strobe edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/status_group.sv
// status_group: condition/transition-filter/event/enable register
// group with one OR-summary bit placed in a status-byte fragment.
// Assumes synchronous condition inputs and a single host master.
module status_group
    import stat_pkg::*;
#(
    parameter int unsigned W       = 16,
    parameter int unsigned SB_W    = 8,
    parameter int unsigned SUM_POS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       cond_i,
    input  logic [STAT_AW-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [W-1:0]       host_wdata,
    output logic [W-1:0]       host_rdata,
    output logic               sum_o,
    output logic [SB_W-1:0]    status_bits_o
);
    logic [W-1:0] cond_q;
    logic [W-1:0] hit;
    logic [W-1:0] evt_q;
    logic [W-1:0] rise_m;
    logic [W-1:0] fall_m;
    logic [W-1:0] ena_m;
    logic         evt_clr;

    // a read of the event address clears it
    assign evt_clr = host_rd && (host_addr == SA_EVT);

    stat_edge #(.W(W)) u_edge (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i),
        .rise_m(rise_m), .fall_m(fall_m), .cond_q(cond_q), .hit(hit)
    );

    stat_evt #(.W(W)) u_evt (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(evt_clr), .evt_q(evt_q)
    );

    stat_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(host_addr), .rd(host_rd),
        .wr(host_wr), .wdata(host_wdata), .cond_i(cond_i), .evt_q(evt_q),
        .rise_m(rise_m), .fall_m(fall_m), .ena_m(ena_m), .rdata(host_rdata)
    );

    // masked OR summary, combinational from registered state
    assign sum_o = |(evt_q & ena_m);

    // place the summary at its fixed status-byte position
    for (genvar b = 0; b < SB_W; b++) begin : g_sb
        if (b == SUM_POS) begin : g_on
            assign status_bits_o[b] = sum_o;
        end else begin : g_off
            assign status_bits_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/status_group_chk.sv
// status_group_chk: temporal properties of the status register group,
// attached to every status_group instance through bind.
module status_group_chk
    import stat_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter int unsigned SB_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [W-1:0]       cond_i,
    input logic [W-1:0]       cond_q,
    input logic [W-1:0]       rise_m,
    input logic [W-1:0]       fall_m,
    input logic [W-1:0]       ena_m,
    input logic [W-1:0]       evt_q,
    input logic [STAT_AW-1:0] host_addr,
    input logic               host_rd,
    input logic               host_wr,
    input logic [W-1:0]       host_rdata,
    input logic               sum_o,
    input logic [SB_W-1:0]    status_bits_o
);
    assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cond_i) & ~$past(cond_q) & $past(rise_m)) & ~evt_q) == '0));

    assert_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((~$past(cond_i) & $past(cond_q) & $past(fall_m)) & ~evt_q) == '0));

    assert_evt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_addr == SA_EVT) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    assert_read_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == SA_EVT) |=> (host_rdata == $past(evt_q)));

    assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == SA_EVT) |=>
        ((evt_q & ~(($past(cond_i) & ~$past(cond_q) & $past(rise_m)) |
                    (~$past(cond_i) & $past(cond_q) & $past(fall_m)))) == '0));

    assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == SA_MASK) |=> $stable(ena_m));

    assert_masks_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && (host_addr == SA_RISE || host_addr == SA_FALL)) |=>
        ($stable(rise_m) && $stable(fall_m)));

    assert_fragment_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_bits_o) == (sum_o ? 1 : 0));
endmodule

bind status_group status_group_chk #(.W(W), .SB_W(SB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .cond_q(cond_q),
    .rise_m(rise_m), .fall_m(fall_m), .ena_m(ena_m), .evt_q(evt_q),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_rdata(host_rdata), .sum_o(sum_o), .status_bits_o(status_bits_o)
);

// File: tb/sim_status_group.sv
// sim_status_group: directed bench, one task per scenario.
module sim_status_group;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cond_i = '0;
    logic [2:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        sum_o;
    logic [7:0]  status_bits_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    status_group u0 (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .sum_o(sum_o), .status_bits_o(status_bits_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // register read: strobe for one edge, sample at the next falling edge
    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        host_addr = a; host_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic set_cond(input logic [15:0] v);
        @(negedge clk);
        cond_i = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        cond_i = 16'h0005;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 summary", {15'd0, sum_o}, 16'h0);
        check("R1 fragment", {8'd0, status_bits_o}, 16'h0);
        reg_rd(3'd1, d); check("R1 rise mask", d, 16'hFFFF);
        reg_rd(3'd2, d); check("R1 fall mask", d, 16'h0000);
        reg_rd(3'd4, d); check("R1 enable", d, 16'h0000);
        reg_rd(3'd3, d); check("R12 no event at reset release", d, 16'h0000);
    endtask

    task automatic t_cond();
        logic [15:0] d;
        set_cond(16'h1234);
        reg_rd(3'd0, d); check("R2 condition read", d, 16'h1234);
        reg_wr(3'd0, 16'hFFFF);
        reg_rd(3'd0, d); check("R2 condition write ignored", d, 16'h1234);
        reg_rd(3'd3, d); check("R3 rising edges latched", d, 16'h1230);
        set_cond(16'h0000);
        reg_rd(3'd3, d); check("R4 falling edge with zero mask", d, 16'h0000);
    endtask

    task automatic t_fall();
        logic [15:0] d;
        reg_wr(3'd2, 16'h00F0);
        reg_wr(3'd1, 16'h0000);
        set_cond(16'h00FF);
        reg_rd(3'd3, d); check("R3 rising edge with zero mask", d, 16'h0000);
        set_cond(16'h000F);
        set_cond(16'h00FF);
        reg_rd(3'd3, d); check("R5 event sticky after return", d, 16'h00F0);
        reg_rd(3'd3, d); check("R6 cleared by read", d, 16'h0000);
        reg_rd(3'd2, d); check("R4 fall mask readback", d, 16'h00F0);
    endtask

    task automatic t_enable();
        logic [15:0] d;
        reg_wr(3'd1, 16'hFFFF);
        reg_wr(3'd4, 16'h0010);
        reg_rd(3'd4, d); check("R9 enable readback", d, 16'h0010);
        set_cond(16'h01FF);
        check("R9 disabled event gives no summary", {15'd0, sum_o}, 16'h0);
        set_cond(16'h01EF);
        check("R9 enabled event sets summary", {15'd0, sum_o}, 16'h1);
        check("R10 summary at bit 3", {8'd0, status_bits_o}, 16'h0008);
        reg_wr(3'd4, 16'h0000);
        check("R9 summary follows enable write", {15'd0, sum_o}, 16'h0);
        reg_wr(3'd4, 16'h0010);
        check("R9 summary returns with enable", {15'd0, sum_o}, 16'h1);
        reg_rd(3'd3, d); check("R6 read returns both events", d, 16'h0110);
        check("R9 summary drops on clear", {15'd0, sum_o}, 16'h0);
    endtask

    task automatic t_evt_write();
        logic [15:0] d;
        reg_wr(3'd3, 16'hFFFF);
        reg_rd(3'd3, d); check("R8 event write ignored", d, 16'h0000);
        check("R8 summary after event write", {15'd0, sum_o}, 16'h0);
    endtask

    task automatic t_race();
        logic [15:0] d;
        set_cond(16'h03EF);
        @(negedge clk);
        host_addr = 3'd3; host_rd = 1'b1; cond_i = 16'h83EF;
        @(negedge clk);
        host_rd = 1'b0;
        check("R7 read returns old value", host_rdata, 16'h0200);
        reg_rd(3'd3, d); check("R7 new edge survives clear", d, 16'h8000);
    endtask

    task automatic t_addr();
        logic [15:0] d;
        for (int a = 5; a < 8; a++) begin
            reg_rd(3'(a), d); check("R11 unused address reads zero", d, 16'h0000);
        end
        reg_wr(3'd5, 16'hAAAA);
        reg_wr(3'd7, 16'h5555);
        reg_rd(3'd2, d); check("R11 fall mask unchanged", d, 16'h00F0);
        reg_rd(3'd1, d); check("R11 rise mask unchanged", d, 16'hFFFF);
        reg_rd(3'd4, d); check("R11 enable unchanged", d, 16'h0010);
    endtask

    initial begin
        t_reset();
        t_cond();
        t_fall();
        t_enable();
        t_evt_write();
        t_race();
        t_addr();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule